// File: doc/BRIEF.md
# Multi-Cycle 32-bit Subset Processor Core

This block is a small 32-bit processor core that runs each instruction over several clock cycles on one shared datapath. A single ALU handles the PC increment, the speculative branch target, the branch compare and the operand or address arithmetic, each in its own state. A single memory port, with a combinational read, carries both instruction fetches and data accesses. Holding registers for the instruction word, the loaded data word, the two operands and the ALU result carry values from one state to the next.

The core executes loads, stores, the register-register operations add, sub, and, or and signed set-less-than, branch-if-equal and an absolute jump. The cycle count per instruction depends on its class. It is meant to sit beside a zero-wait memory. The output `fetch_cycle` marks the first cycle of every instruction, so an observer can time each instruction.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high (sampled at a rising edge) the core is in the fetch state, with PC 0 and all 32 general registers cleared. After reset, the first fetch reads address 0.
- R2: In a fetch cycle `fetch_cycle` is high, `mem_addr` equals the PC and the returned word becomes the current instruction. The PC then advances by 4.
- R3: An instruction with opcode 0 (bits 31:26) takes 4 cycles. It writes rs op rt into the register at bits 15:11, where rs is bits 25:21 and rt is bits 20:16. The function field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A set-less-than (signed, result 1 or 0).
- R4: A load (opcode 0x23) takes 5 cycles. It writes the memory word at rs plus the sign-extended bits 15:0 into register rt.
- R5: A store (opcode 0x2B) takes 4 cycles. In its fourth cycle, and only then, `mem_we` is high for one cycle, with `mem_addr` equal to rs plus the sign-extended offset and `mem_wdata` equal to rt.
- R6: A branch (opcode 0x04) takes 3 cycles whether taken or not. When rs equals rt, the next PC is the incremented PC plus the sign-extended offset shifted left by 2. Otherwise execution continues at the incremented PC.
- R7: A jump (opcode 0x02) takes 3 cycles. It sets the PC to the upper 4 bits of the incremented PC, then bits 25:0 of the instruction, then two zero bits.
- R8: Register 0 always reads as zero, and a write aimed at it is discarded.
- R9: Any other opcode takes 2 cycles and changes no register and no memory. Only the PC advance of its fetch takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address for the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Write strobe for the addressed word |
| mem_rdata | input | 32 | Word read combinationally at `mem_addr` |
| fetch_cycle | output | 1 | High in the first cycle of every instruction |

## Verification
Each instruction's class sets how many cycles pass before the next fetch: 2 for an unknown opcode, 3 for branch and jump, 4 for register ops and stores, 5 for loads. The bench expects that many cycles between successive `fetch_cycle` samples. A store's write strobe is due in the fourth cycle of its instruction. The bench samples it, together with the address and the data, at the falling edge inside that cycle. Register results are not visible at the ports until a later store copies them out. Those values are therefore checked one instruction later, through the scoreboard of expected writes, and the skipped stores are checked in the memory at the end of the run.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int XLEN  = 32;
    localparam int RIDX  = 5;
    localparam int NREGS = 1 << RIDX;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_EXEC_R, ST_ADDR, ST_BRANCH,
        ST_JUMP, ST_WB_R, ST_STORE, ST_LOAD, ST_WB_LD
    } mc_state_e;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;
    typedef enum logic [0:0] {SA_PC, SA_REG} src_a_e;
    typedef enum logic [1:0] {SB_REG, SB_FOUR, SB_IMM, SB_IMM_SH} src_b_e;
    typedef enum logic [1:0] {PN_ALU, PN_HELD, PN_JUMP} pc_next_e;

    typedef struct packed {
        logic     pc_we;
        logic     pc_cond;
        pc_next_e pc_src;
        logic     ir_we;
        logic     mdr_we;
        logic     ab_we;
        logic     res_we;
        src_a_e   src_a;
        src_b_e   src_b;
        alu_op_e  op;
        logic     mem_we;
        logic     addr_pc;
        logic     rf_we;
        logic     dst_rd;
        logic     from_mdr;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] imm);
        return {{(XLEN-16){imm[15]}}, imm};
    endfunction

    function automatic alu_op_e funct_op(input logic [5:0] fn);
        case (fn)
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_pkg::*;
#(
    parameter int AW = RIDX,
    parameter int DW = XLEN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd1,
    output logic [DW-1:0] rd2,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);
    localparam int N = 1 << AW;

    logic [DW-1:0] regs [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign regs[i] = '0;
        end else begin : g_ff
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (we && wa == AW'(i))
                    regs[i] <= wd;
            end
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output logic       in_fetch
);
    mc_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt = ST_FETCH;
        case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opcode)
                    OP_RTYPE:          nxt = ST_EXEC_R;
                    OP_LOAD, OP_STORE: nxt = ST_ADDR;
                    OP_BEQ:            nxt = ST_BRANCH;
                    OP_JUMP:           nxt = ST_JUMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_EXEC_R: nxt = ST_WB_R;
            ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_LOAD : ST_STORE;
            ST_LOAD:   nxt = ST_WB_LD;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        ctl.src_a = SA_REG;
        ctl.src_b = SB_REG;
        ctl.op    = ALU_ADD;
        ctl.pc_src = PN_ALU;
        case (state)
            ST_FETCH: begin
                ctl.addr_pc = 1'b1;
                ctl.ir_we   = 1'b1;
                ctl.pc_we   = 1'b1;
                ctl.src_a   = SA_PC;
                ctl.src_b   = SB_FOUR;
            end
            ST_DECODE: begin
                ctl.ab_we  = 1'b1;
                ctl.res_we = 1'b1;
                ctl.src_a  = SA_PC;
                ctl.src_b  = SB_IMM_SH;
            end
            ST_EXEC_R: begin
                ctl.res_we = 1'b1;
                ctl.op     = funct_op(funct);
            end
            ST_ADDR: begin
                ctl.res_we = 1'b1;
                ctl.src_b  = SB_IMM;
            end
            ST_BRANCH: begin
                ctl.op      = ALU_SUB;
                ctl.pc_cond = 1'b1;
                ctl.pc_src  = PN_HELD;
            end
            ST_JUMP: begin
                ctl.pc_we  = 1'b1;
                ctl.pc_src = PN_JUMP;
            end
            ST_WB_R: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
            end
            ST_STORE: ctl.mem_we = 1'b1;
            ST_LOAD:  ctl.mdr_we = 1'b1;
            ST_WB_LD: begin
                ctl.rf_we    = 1'b1;
                ctl.from_mdr = 1'b1;
            end
            default: ;
        endcase
    end

    assign in_fetch = (state == ST_FETCH);
endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            fetch_cycle
);
    ctrl_t           ctl;
    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
    logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wd;
    logic [RIDX-1:0] rf_wa;
    logic [XLEN-1:0] alu_a, alu_b, alu_y, imm_x, pc_nxt;
    logic            alu_zero;
    logic            unused_shamt;

    assign unused_shamt = ^ir_q[10:6];
    assign imm_x = sext16(ir_q[15:0]);

    mc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opcode   (ir_q[31:26]),
        .funct    (ir_q[5:0]),
        .ctl      (ctl),
        .in_fetch (fetch_cycle)
    );

    assign rf_wa = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
    assign rf_wd = ctl.from_mdr ? mdr_q : res_q;

    mc_regfile #(.AW(RIDX), .DW(XLEN)) u_rf (
        .clk (clk),
        .rst (rst),
        .ra1 (ir_q[25:21]),
        .ra2 (ir_q[20:16]),
        .rd1 (rf_rd1),
        .rd2 (rf_rd2),
        .we  (ctl.rf_we),
        .wa  (rf_wa),
        .wd  (rf_wd)
    );

    assign alu_a = (ctl.src_a == SA_PC) ? pc_q : a_q;
    always_comb begin
        case (ctl.src_b)
            SB_FOUR:   alu_b = XLEN'(4);
            SB_IMM:    alu_b = imm_x;
            SB_IMM_SH: alu_b = {imm_x[XLEN-3:0], 2'b00};
            default:   alu_b = b_q;
        endcase
    end

    mc_alu #(.DW(XLEN)) u_alu (
        .a    (alu_a),
        .b    (alu_b),
        .op   (ctl.op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        case (ctl.pc_src)
            PN_HELD: pc_nxt = res_q;
            PN_JUMP: pc_nxt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
            default: pc_nxt = alu_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            if (ctl.pc_we || (ctl.pc_cond && alu_zero)) pc_q <= pc_nxt;
            if (ctl.ir_we)  ir_q  <= mem_rdata;
            if (ctl.mdr_we) mdr_q <= mem_rdata;
            if (ctl.ab_we) begin
                a_q <= rf_rd1;
                b_q <= rf_rd2;
            end
            if (ctl.res_we) res_q <= alu_y;
        end
    end

    assign mem_addr  = ctl.addr_pc ? pc_q : res_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctl.mem_we;
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        fetch_cycle,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] pc,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_data
);
    AST_RESET_TO_FETCH: assert property (@(posedge clk)
        rst |=> (fetch_cycle && mem_addr == 32'd0 && pc == 32'd0)); // R1

    AST_FETCH_ADDR_PC: assert property (@(posedge clk) disable iff (rst)
        fetch_cycle |-> (mem_addr == pc)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        fetch_cycle |=> (pc == $past(pc) + 32'd4)); // R2

    AST_STORE_LAST_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (fetch_cycle && !mem_we)); // R5

    AST_NO_STORE_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
        fetch_cycle |-> !mem_we); // R5

    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> (rs_data == 32'd0)); // R8

    AST_MIN_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
        fetch_cycle |=> !fetch_cycle); // R9
endmodule

bind mc_core mc_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_cycle (fetch_cycle),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .pc          (pc_q),
    .rs_idx      (ir_q[25:21]),
    .rs_data     (rf_rd1)
);

// File: tb/mc_core_test.sv
module mc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, fetch_cycle;

    logic [31:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_idx = '0;
    logic [31:0] ld_val = '0;

    int errors = 0;
    int checks = 0;

    typedef struct { int cyc; string tag; } cyc_item_t;
    typedef struct { logic [31:0] addr; logic [31:0] data; string tag; } st_item_t;
    cyc_item_t cyc_q[$];
    st_item_t  st_q[$];

    always #4 clk = ~clk;

    mc_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .fetch_cycle(fetch_cycle)
    );

    assign mem_rdata = mem[mem_addr[9:2]];
    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_val;
        else if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [31:0] w);
        @(negedge clk);
        ld_en = 1'b1; ld_idx = 8'(idx); ld_val = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic expect_instr(input int cyc, input string tag);
        cyc_item_t it;
        it.cyc = cyc; it.tag = tag;
        cyc_q.push_back(it);
    endtask

    task automatic expect_store(input logic [31:0] a, input logic [31:0] d, input string tag);
        st_item_t it;
        it.addr = a; it.data = d; it.tag = tag;
        st_q.push_back(it);
    endtask

    // monitor: instruction length between fetch cycles, and store writes
    int  run_cnt = 0;
    bit  started = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (fetch_cycle) begin
                if (started && cyc_q.size() != 0) begin
                    cyc_item_t it;
                    it = cyc_q.pop_front();
                    check(run_cnt == it.cyc, it.tag, 32'(run_cnt), 32'(it.cyc));
                end
                started = 1'b1;
                run_cnt = 1;
            end else begin
                run_cnt++;
            end
            if (mem_we) begin
                if (st_q.size() == 0) begin
                    check(1'b0, "R5 unexpected store", mem_addr, 32'hFFFFFFFF);
                end else begin
                    st_item_t s;
                    s = st_q.pop_front();
                    check(mem_addr == s.addr, {s.tag, " addr"}, mem_addr, s.addr);
                    check(mem_wdata == s.data, {s.tag, " data"}, mem_wdata, s.data);
                end
            end
        end
    end

    initial begin
        int wd;
        for (int i = 0; i < 256; i++) put(i, 32'd0);
        // data words
        put(64, 32'h0000_0007);
        put(65, 32'hFFFF_FFF0);
        put(66, 32'h0000_0228);
        // program
        put(0,  enc_i(6'h23, 0, 1, 16'h0100));
        put(1,  enc_i(6'h23, 0, 2, 16'h0104));
        put(2,  enc_r(1, 2, 3, 6'h20));
        put(3,  enc_r(1, 2, 4, 6'h22));
        put(4,  enc_r(1, 2, 5, 6'h24));
        put(5,  enc_r(1, 2, 6, 6'h25));
        put(6,  enc_r(2, 1, 7, 6'h2A));
        put(7,  enc_r(1, 2, 8, 6'h2A));
        put(8,  enc_r(1, 1, 0, 6'h20));
        put(9,  enc_i(6'h2B, 0, 3, 16'h0200));
        put(10, enc_i(6'h2B, 0, 4, 16'h0204));
        put(11, enc_i(6'h2B, 0, 5, 16'h0208));
        put(12, enc_i(6'h2B, 0, 6, 16'h020C));
        put(13, enc_i(6'h2B, 0, 7, 16'h0210));
        put(14, enc_i(6'h2B, 0, 8, 16'h0214));
        put(15, enc_i(6'h2B, 0, 0, 16'h0218));
        put(16, {6'h3F, 5'd1, 5'd2, 16'h1234});
        put(17, enc_i(6'h04, 1, 2, 16'h0005));
        put(18, enc_i(6'h04, 1, 1, 16'h0002));
        put(19, enc_i(6'h2B, 0, 1, 16'h021C));
        put(20, enc_i(6'h2B, 0, 1, 16'h021C));
        put(21, enc_i(6'h2B, 0, 2, 16'h0220));
        put(22, enc_i(6'h23, 0, 10, 16'h0108));
        put(23, enc_i(6'h2B, 10, 1, 16'hFFFC));
        put(24, {6'h02, 26'd26});
        put(25, enc_i(6'h2B, 0, 1, 16'h021C));
        put(26, enc_i(6'h04, 0, 0, 16'hFFFF));

        // R1: state held in reset
        @(negedge clk);
        check(fetch_cycle == 1'b1, "R1 fetch in reset", 32'(fetch_cycle), 32'd1);
        check(mem_addr == 32'd0, "R1 pc zero in reset", mem_addr, 32'd0);
        check(mem_we == 1'b0, "R1 no write in reset", 32'(mem_we), 32'd0);

        expect_instr(5, "R4 load cycles");
        expect_instr(5, "R4 load cycles");
        for (int i = 0; i < 7; i++) expect_instr(4, "R3 rtype cycles");
        for (int i = 0; i < 7; i++) expect_instr(4, "R5 store cycles");
        expect_instr(2, "R9 unknown opcode cycles");
        expect_instr(3, "R6 branch not taken cycles");
        expect_instr(3, "R6 branch taken cycles");
        expect_instr(4, "R5 store cycles");
        expect_instr(5, "R4 load cycles");
        expect_instr(4, "R5 store cycles");
        expect_instr(3, "R7 jump cycles");
        for (int i = 0; i < 3; i++) expect_instr(3, "R6 backward branch cycles");

        expect_store(32'h200, 32'hFFFF_FFF7, "R3 add result");
        expect_store(32'h204, 32'h0000_0017, "R3 sub result");
        expect_store(32'h208, 32'h0000_0000, "R3 and result");
        expect_store(32'h20C, 32'hFFFF_FFF7, "R3 or result");
        expect_store(32'h210, 32'h0000_0001, "R3 slt true signed");
        expect_store(32'h214, 32'h0000_0000, "R3 slt false");
        expect_store(32'h218, 32'h0000_0000, "R8 r0 after write");
        expect_store(32'h220, 32'hFFFF_FFF0, "R9 r2 unchanged");
        expect_store(32'h224, 32'h0000_0007, "R4 negative offset");

        @(negedge clk);
        rst = 1'b0;
        wd = 0;
        while (cyc_q.size() != 0 && wd < 5000) begin
            @(negedge clk);
            wd++;
        end
        check(wd < 5000, "watchdog expired", 32'(wd), 32'd5000);
        check(st_q.size() == 0, "R5 stores outstanding", 32'(st_q.size()), 32'd0);
        check(mem[135] == 32'd0, "R6 R7 skipped stores", mem[135], 32'd0);
        check(mem[128] == 32'hFFFF_FFF7, "R5 memory written", mem[128], 32'hFFFF_FFF7);
        check(mem[137] == 32'd7, "R4 memory written", mem[137], 32'd7);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule